// File: doc/BRIEF.md
# Half-Duplex Modem Direction Arbiter

This block decides, cycle by cycle, whether a half-duplex modem is listening or talking. It enables exactly one of two datapaths, the demodulator (receive) or the modulator (transmit), and never both. Receive is the default. The host asks to talk by raising a request-to-send input. The arbiter holds that request back for as long as the demodulator reports a valid carrier, so it never transmits over an incoming frame.

Each change of direction passes through a turnaround gap in which both enables are low. The gap is `GAP_CYCLES` long and defaults to one cycle. Two status bits summarise what the arbiter is doing. Bit 0 is clear-to-send: the host's grant to transmit. Bit 1 is carrier-detect: the arbiter was receiving and a carrier was present.

When the host withdraws its request, clear-to-send drops at once. If the transmit queue still holds data, the modulator stays on until the queue is empty, and only then does the arbiter turn back to receive.

Top module: `duplex_dir_arb`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the demodulator enable is 1, the modulator enable is 0, and both status bits are 0.
- R2: The modulator enable and the demodulator enable are never both 1.
- R3: Status bit 1 (carrier-detect) is 1 in a cycle exactly when, at the previous clock edge, the arbiter was receiving and the carrier input was 1.
- R4: Status bit 0 (clear-to-send) is 1 only while the modulator is enabled and the transmit request is held.
- R5: A transmit request raised while the carrier input is 1 is not granted. The demodulator stays enabled until the carrier drops.
- R6: Once a request is accepted with no carrier, both enables are low for `GAP_CYCLES` cycles. After that the modulator is enabled and clear-to-send rises.
- R7: When the request is cleared and the transmit queue is empty, clear-to-send drops and both enables go low for `GAP_CYCLES` cycles. After that the demodulator is enabled.
- R8: When the request is cleared and the transmit queue is not empty, clear-to-send drops, but the modulator stays enabled until the queue reports empty.
- R9: If the request is raised again while the modulator is still draining, clear-to-send returns on the next cycle without a turnaround gap.
- R10: If the request is withdrawn during the gap towards transmit, the modulator is never enabled, and the arbiter returns to receive after a fresh gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rts_i | input | 1 | Host request to transmit |
| carrier_i | input | 1 | Valid carrier seen by the demodulator |
| txq_empty_i | input | 1 | Transmit queue is empty |
| mod_en_o | output | 1 | Modulator enable |
| demod_en_o | output | 1 | Demodulator enable |
| stat_o | output | 2 | Status: bit 0 clear-to-send, bit 1 carrier-detect |

## Verification
The hardest states to reach from the ports are the two mid-turnaround branches. One is a request withdrawn inside the gap towards transmit. The other is a request re-raised while the modulator drains a non-empty queue.

Both need the request, carrier and queue-empty inputs placed on exact cycles relative to the gap. The stimulus table therefore walks a cycle-accurate script that lands on each of these cycles. A request is also held against a live carrier for several cycles. Directed steps afterwards cover reset, including a reset that arrives while transmitting.

// File: rtl/duplex_arb_pkg.sv
`timescale 1ns/1ps
package duplex_arb_pkg;

    typedef enum logic [2:0] {
        DIR_RX    = 3'd0,
        DIR_TO_TX = 3'd1,
        DIR_TX    = 3'd2,
        DIR_DRAIN = 3'd3,
        DIR_TO_RX = 3'd4
    } dir_state_e;

    typedef struct packed {
        dir_state_e state;
    } fsm_regs_t;

    typedef struct packed {
        logic cd;
    } stat_regs_t;

endpackage

// File: rtl/duplex_gap_timer.sv
`timescale 1ns/1ps
module duplex_gap_timer #(
    parameter int GAP_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic done_o
);
    localparam int CNT_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(GAP_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = RELOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/duplex_dir_fsm.sv
`timescale 1ns/1ps
module duplex_dir_fsm
    import duplex_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rts_i,
    input  logic       carrier_i,
    input  logic       txq_empty_i,
    input  logic       gap_done_i,
    output logic       gap_load_o,
    output dir_state_e state_o
);
    fsm_regs_t regs_d, regs_q;

    always_comb begin
        regs_d     = regs_q;
        gap_load_o = 1'b0;
        unique case (regs_q.state)
            DIR_RX: begin
                if (rts_i && !carrier_i) begin
                    regs_d.state = DIR_TO_TX;
                    gap_load_o   = 1'b1;
                end
            end
            DIR_TO_TX: begin
                if (!rts_i) begin
                    regs_d.state = DIR_TO_RX;
                    gap_load_o   = 1'b1;
                end else if (gap_done_i) begin
                    regs_d.state = DIR_TX;
                end
            end
            DIR_TX: begin
                if (!rts_i) begin
                    if (txq_empty_i) begin
                        regs_d.state = DIR_TO_RX;
                        gap_load_o   = 1'b1;
                    end else begin
                        regs_d.state = DIR_DRAIN;
                    end
                end
            end
            DIR_DRAIN: begin
                if (rts_i) begin
                    regs_d.state = DIR_TX;
                end else if (txq_empty_i) begin
                    regs_d.state = DIR_TO_RX;
                    gap_load_o   = 1'b1;
                end
            end
            DIR_TO_RX: begin
                if (gap_done_i) begin
                    regs_d.state = DIR_RX;
                end
            end
            default: begin
                regs_d.state = DIR_RX;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state <= DIR_RX;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_o = regs_q.state;
endmodule

// File: rtl/duplex_stat_gen.sv
`timescale 1ns/1ps
module duplex_stat_gen
    import duplex_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  dir_state_e state_i,
    input  logic       carrier_i,
    output logic       mod_en_o,
    output logic       demod_en_o,
    output logic [1:0] stat_o
);
    stat_regs_t regs_d, regs_q;

    always_comb begin
        regs_d    = regs_q;
        regs_d.cd = carrier_i && (state_i == DIR_RX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.cd <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign demod_en_o = (state_i == DIR_RX);
    assign mod_en_o   = (state_i == DIR_TX) || (state_i == DIR_DRAIN);
    assign stat_o[0]  = (state_i == DIR_TX);
    assign stat_o[1]  = regs_q.cd;
endmodule

// File: rtl/duplex_dir_arb.sv
`timescale 1ns/1ps
module duplex_dir_arb
    import duplex_arb_pkg::*;
#(
    parameter int GAP_CYCLES = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rts_i,
    input  logic       carrier_i,
    input  logic       txq_empty_i,
    output logic       mod_en_o,
    output logic       demod_en_o,
    output logic [1:0] stat_o
);
    logic       gap_load;
    logic       gap_done;
    dir_state_e dir_state;

    duplex_gap_timer #(
        .GAP_CYCLES(GAP_CYCLES)
    ) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (gap_load),
        .done_o (gap_done)
    );

    duplex_dir_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rts_i       (rts_i),
        .carrier_i   (carrier_i),
        .txq_empty_i (txq_empty_i),
        .gap_done_i  (gap_done),
        .gap_load_o  (gap_load),
        .state_o     (dir_state)
    );

    duplex_stat_gen u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_i    (dir_state),
        .carrier_i  (carrier_i),
        .mod_en_o   (mod_en_o),
        .demod_en_o (demod_en_o),
        .stat_o     (stat_o)
    );
endmodule

// File: rtl/duplex_dir_arb_chk.sv
`timescale 1ns/1ps
module duplex_dir_arb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rts_i,
    input logic       carrier_i,
    input logic       txq_empty_i,
    input logic       mod_en_o,
    input logic       demod_en_o,
    input logic [1:0] stat_o
);
    // R1
    reset_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (demod_en_o && !mod_en_o));

    // R2
    excl_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mod_en_o && demod_en_o));

    // R3
    cd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[1] |-> $past(carrier_i));

    // R4
    cts_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[0] |-> mod_en_o);

    // R5
    defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (demod_en_o && carrier_i) |=> demod_en_o);

    // R6
    gap_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_en_o) |-> !$past(demod_en_o));

    // R7
    cts_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[0] && !rts_i) |=> !stat_o[0]);

    // R8
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en_o && !rts_i && !txq_empty_i) |=> mod_en_o);
endmodule

bind duplex_dir_arb duplex_dir_arb_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rts_i       (rts_i),
    .carrier_i   (carrier_i),
    .txq_empty_i (txq_empty_i),
    .mod_en_o    (mod_en_o),
    .demod_en_o  (demod_en_o),
    .stat_o      (stat_o)
);

// File: tb/duplex_dir_arb_bench.sv
`timescale 1ns/1ps
module duplex_dir_arb_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rts = 1'b0;
    logic       car = 1'b0;
    logic       emp = 1'b1;
    logic       mod_en, demod_en;
    logic [1:0] stat;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    duplex_dir_arb u_duplex_dir_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .rts_i       (rts),
        .carrier_i   (car),
        .txq_empty_i (emp),
        .mod_en_o    (mod_en),
        .demod_en_o  (demod_en),
        .stat_o      (stat)
    );

    // Each row: {rts, carrier, empty, exp mod, exp demod, exp cts, exp cd}
    localparam int NV = 20;
    localparam logic [6:0] VEC [NV] = '{
        7'b001_0100, // R1 idle receive
        7'b011_0101, // R3 carrier seen
        7'b110_0101, // R5 request deferred
        7'b110_0101, // R5 still deferred
        7'b100_0000, // R6 gap towards transmit
        7'b100_1010, // R6 transmit granted
        7'b110_1010, // R3 carrier ignored while sending
        7'b000_1000, // R8 draining, cts low
        7'b000_1000, // R8 still draining
        7'b100_1010, // R9 regrant with no gap
        7'b001_0000, // R7 gap towards receive
        7'b001_0100, // R7 back to receive
        7'b011_0101, // R3 carrier again
        7'b101_0000, // R6 request accepted
        7'b001_0000, // R10 withdrawn inside gap
        7'b001_0100, // R10 receive again
        7'b101_0000, // R6 gap
        7'b101_1010, // R4 transmit
        7'b001_0000, // R7 gap
        7'b001_0100  // R7 receive
    };

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got mod/demod/cts/cd=%b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {mod_en, demod_en, stat[0], stat[1]};
    endfunction

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk("R1 in reset", outs(), 4'b0100);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", outs(), 4'b0100);

        for (int i = 0; i < NV; i++) begin
            {rts, car, emp} = VEC[i][6:4];
            @(negedge clk);
            chk($sformatf("row %0d", i), outs(), VEC[i][3:0]);
            chk("R2 exclusive", {2'b00, mod_en & demod_en, 1'b0}, 4'b0000);
        end

        // R1: reset arriving while transmitting returns to receive
        rts = 1'b1; car = 1'b0; emp = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 setup transmit", outs(), 4'b1010);
        rst_n = 1'b0;
        #1;
        chk("R1 reset mid transmit", outs(), 4'b0100);
        rts = 1'b0; emp = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", outs(), 4'b0100);

        // R5: long carrier keeps request pending
        rts = 1'b1; car = 1'b1;
        repeat (6) @(negedge clk);
        chk("R5 long deferral", outs(), 4'b0101);
        car = 1'b0;
        @(negedge clk);
        chk("R6 gap after carrier drop", outs(), 4'b0000);
        @(negedge clk);
        chk("R6 grant after carrier drop", outs(), 4'b1010);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule